// File: doc/BRIEF.md
# Parallel Disk Bus Device Register File

This block is the device-side register front end of a parallel disk-style bus. The host drives two chip selects (one for the command block, one for the control block), a 3-bit register offset, and single-cycle read and write strobes. The block decodes each access to the data port, one of the command-block registers, status, alternate status or device control. One offset can reach two different registers: a read gets one register and a write loads the other.

The block holds the parameter registers (features, count, sector, cylinder, device/head) and shows them to a media back-end. A write to the command register launches a command. It raises a one-cycle start pulse with the command byte, and status shows the device as busy until the back-end reports completion. Completion latches the error outcome and raises an interrupt request. A status read acknowledges the interrupt, and a mask bit in device control gates it.

Two devices can share the bus. Each instance has a strapped identity and takes part in command launches, data transfers, read-data drive and interrupts only while the device bit of the device/head register matches that identity.

Top module: `ata_regfile`

## Requirements
- R1: With the command select high and the control select low, offsets 0..7 reach, in that order: data, error/features, count, sector, cylinder low, cylinder high, device/head, status/command. Writes to offsets 1..6 appear on the matching parameter outputs in the following cycle (head = device/head bits 3:0, cylinder = {high, low}).
- R2: With the control select high, the command select low and offset 6, a read returns alternate status and a write loads device control. Any other control-block offset, and both selects high together, reach no register.
- R3: At offset 1, a read returns the error register and a write loads features. At offset 7, a read returns status and a write loads the command register.
- R4: Only reads of data, error, status and alternate status drive the bus (`bus_rdata_oe` high, in the same cycle as the read strobe). Reads of write-only registers leave `bus_rdata_oe` low and `bus_rdata` zero. Register reads return the byte in bits 7:0 and zero in the upper bits.
- R5: The device is selected when device/head bit 4 equals `dev_id`. While deselected, command writes are ignored, nothing is driven on reads, data strobes stay low and `intrq` is low. Parameter, device/head and device control writes are still accepted.
- R6: A command write while selected and not busy gives `cmd_start` high for exactly the next cycle, with `cmd_code` holding the written byte. It also sets BSY until `be_done`. A command write while BSY is set is ignored.
- R7: The status byte has BSY in bit 7, DRDY (= not BSY) in bit 6, DRQ (= `be_drq`) in bit 3 and ERR in bit 0, with the other bits zero. `be_done` while busy latches ERR = `be_err` and the error register = `be_err_code` if `be_err` is set, or 0 if it is not. A new command clears both.
- R8: `be_done` while busy sets a pending interrupt. A status read or a new command clears it. An alternate-status read does not clear it. When `be_done` and a status read fall in the same cycle, the set wins.
- R9: Device control bit 1 masks `intrq` without clearing the pending interrupt. Clearing the bit shows the pending interrupt again.
- R10: A selected data-port read returns `be_rdata` and pulses `data_rd_en` in the same cycle. A selected data-port write pulses `data_wr_en`.
- R11: While `rst_n` is low, every register clears: no busy, no pending interrupt, all parameters zero and device 0 selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dev_id | input | 1 | Strapped device identity (0 or 1) |
| bus_sel_cmd | input | 1 | Command-block select, active high |
| bus_sel_ctl | input | 1 | Control-block select, active high |
| bus_addr | input | 3 | Register offset |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data |
| bus_rdata_oe | output | 1 | Read data drive enable |
| intrq | output | 1 | Interrupt request to host |
| cmd_start | output | 1 | One-cycle command launch pulse |
| cmd_code | output | 8 | Last launched command byte |
| par_feature | output | 8 | Features parameter |
| par_count | output | 8 | Count parameter |
| par_sector | output | 8 | Sector parameter |
| par_cyl | output | 16 | Cylinder parameter |
| par_head | output | 4 | Head parameter |
| be_done | input | 1 | Back-end command complete |
| be_err | input | 1 | Back-end error flag, valid with be_done |
| be_err_code | input | 8 | Back-end error code, valid with be_done |
| be_drq | input | 1 | Back-end data request level |
| be_rdata | input | 16 | Back-end data word for data-port reads |
| data_rd_en | output | 1 | Data-port read pulse to back-end |
| data_wr_en | output | 1 | Data-port write pulse to back-end |

## Verification
The hardest state to reach is a pending interrupt that is hidden: the device has to finish a command and then become hidden, either by the mask bit or by the host re-pointing the device bit at the other identity. After that, the interrupt must reappear with no further back-end activity. The stimulus builds this up step by step: a command is launched, completed with an error code, masked, unmasked, then the device is deselected while other registers keep taking writes. After that, a long mixed run of random accesses is made with sparse completion pulses, and every output is compared against a behavioural model on each clock. This run lands completion on the same cycle as status reads and lands command writes while busy.

// File: rtl/ata_pkg.sv
// Shared types and constants for the disk bus register file.
// Assumes one access per cycle, at most one of read/write strobes high.
package ata_pkg;
    typedef enum logic [3:0] {
        ACC_NONE, ACC_DATA, ACC_ERRFEAT, ACC_COUNT, ACC_SECT,
        ACC_CYLL, ACC_CYLH, ACC_DEVHEAD, ACC_STATCMD, ACC_CTL
    } acc_t;

    localparam int DEV_BIT  = 4;
    localparam int NIEN_BIT = 1;

    // Assemble the status byte from its live fields.
    function automatic logic [7:0] status_byte(input logic bsy, input logic drq, input logic err);
        status_byte = {bsy, ~bsy, 2'b00, drq, 2'b00, err};
    endfunction
endpackage

// File: rtl/ata_addr_dec.sv
// Address decoder: maps the two selects and offset to one register slot.
// Assumes selects are active high; both high together reach nothing.
module ata_addr_dec
    import ata_pkg::*;
#(
    parameter int ADDR_W     = 3,
    parameter int CTL_OFFSET = 6
) (
    input  logic              sel_cmd,
    input  logic              sel_ctl,
    input  logic [ADDR_W-1:0] addr,
    output acc_t              acc
);
    // Pure combinational slot selection.
    always_comb begin
        acc = ACC_NONE;
        if (sel_cmd && !sel_ctl) begin
            case (addr)
                3'd0:    acc = ACC_DATA;
                3'd1:    acc = ACC_ERRFEAT;
                3'd2:    acc = ACC_COUNT;
                3'd3:    acc = ACC_SECT;
                3'd4:    acc = ACC_CYLL;
                3'd5:    acc = ACC_CYLH;
                3'd6:    acc = ACC_DEVHEAD;
                default: acc = ACC_STATCMD;
            endcase
        end else if (sel_ctl && !sel_cmd && addr == ADDR_W'(CTL_OFFSET)) begin
            acc = ACC_CTL;
        end
    end
endmodule

// File: rtl/ata_param_regs.sv
// Parameter storage: features, count, sector, cylinder, device/head and
// device control. Accepted regardless of device selection.
module ata_param_regs
    import ata_pkg::*;
#(
    parameter int REG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  acc_t             acc,
    input  logic [REG_W-1:0] wbyte,
    output logic [REG_W-1:0] feature,
    output logic [REG_W-1:0] count,
    output logic [REG_W-1:0] sector,
    output logic [REG_W-1:0] cyl_lo,
    output logic [REG_W-1:0] cyl_hi,
    output logic [REG_W-1:0] devhead,
    output logic [REG_W-1:0] devctl
);
    // Load the addressed parameter register on a write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            feature <= '0; count <= '0; sector <= '0;
            cyl_lo  <= '0; cyl_hi <= '0; devhead <= '0; devctl <= '0;
        end else if (wr) begin
            case (acc)
                ACC_ERRFEAT: feature <= wbyte;
                ACC_COUNT:   count   <= wbyte;
                ACC_SECT:    sector  <= wbyte;
                ACC_CYLL:    cyl_lo  <= wbyte;
                ACC_CYLH:    cyl_hi  <= wbyte;
                ACC_DEVHEAD: devhead <= wbyte;
                ACC_CTL:     devctl  <= wbyte;
                default:     ;
            endcase
        end
    end
endmodule

// File: rtl/ata_status_ctl.sv
// Command launch and completion tracking: busy, error latch, interrupt
// pending and the start pulse. Assumes cmd_go already includes selection.
module ata_status_ctl #(
    parameter int REG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_go,
    input  logic             stat_rd,
    input  logic [REG_W-1:0] wbyte,
    input  logic             be_done,
    input  logic             be_err,
    input  logic [REG_W-1:0] be_err_code,
    output logic             bsy,
    output logic             err_flag,
    output logic [REG_W-1:0] err_code,
    output logic             pend,
    output logic             cmd_start,
    output logic [REG_W-1:0] cmd_code
);
    // Launch on accepted command, retire on back-end done, ack on status read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bsy <= 1'b0; err_flag <= 1'b0; err_code <= '0;
            pend <= 1'b0; cmd_start <= 1'b0; cmd_code <= '0;
        end else begin
            cmd_start <= 1'b0;
            if (cmd_go && !bsy) begin
                bsy       <= 1'b1;
                cmd_start <= 1'b1;
                cmd_code  <= wbyte;
                err_flag  <= 1'b0;
                err_code  <= '0;
                pend      <= 1'b0;
            end else if (be_done && bsy) begin
                bsy      <= 1'b0;
                err_flag <= be_err;
                err_code <= be_err ? be_err_code : '0;
                pend     <= 1'b1;
            end else if (stat_rd) begin
                pend <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/ata_regfile.sv
// Top of the device register file: decode, parameter storage, command
// tracking, read mux, device selection and interrupt gating.
// Assumes strobes are synchronous single-cycle pulses on clk.
module ata_regfile
    import ata_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int REG_W      = 8,
    parameter int ADDR_W     = 3,
    parameter int HEAD_W     = 4,
    parameter int CTL_OFFSET = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dev_id,
    input  logic              bus_sel_cmd,
    input  logic              bus_sel_ctl,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_rdata_oe,
    output logic              intrq,
    output logic              cmd_start,
    output logic [REG_W-1:0]  cmd_code,
    output logic [REG_W-1:0]  par_feature,
    output logic [REG_W-1:0]  par_count,
    output logic [REG_W-1:0]  par_sector,
    output logic [2*REG_W-1:0] par_cyl,
    output logic [HEAD_W-1:0] par_head,
    input  logic              be_done,
    input  logic              be_err,
    input  logic [REG_W-1:0]  be_err_code,
    input  logic              be_drq,
    input  logic [DATA_W-1:0] be_rdata,
    output logic              data_rd_en,
    output logic              data_wr_en
);
    localparam int PAD_W = DATA_W - REG_W;

    acc_t             acc;
    logic [REG_W-1:0] wbyte, cyl_lo, cyl_hi, devhead, devctl;
    logic [REG_W-1:0] err_code, stat;
    logic             selected, bsy_q, err_flag, pend_q, nien;

    assign wbyte = bus_wdata[REG_W-1:0];

    ata_addr_dec #(.ADDR_W(ADDR_W), .CTL_OFFSET(CTL_OFFSET)) u_dec (
        .sel_cmd(bus_sel_cmd), .sel_ctl(bus_sel_ctl), .addr(bus_addr), .acc(acc)
    );

    ata_param_regs #(.REG_W(REG_W)) u_par (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr), .acc(acc), .wbyte(wbyte),
        .feature(par_feature), .count(par_count), .sector(par_sector),
        .cyl_lo(cyl_lo), .cyl_hi(cyl_hi), .devhead(devhead), .devctl(devctl)
    );

    ata_status_ctl #(.REG_W(REG_W)) u_stat (
        .clk(clk), .rst_n(rst_n),
        .cmd_go(bus_wr && selected && acc == ACC_STATCMD),
        .stat_rd(bus_rd && selected && acc == ACC_STATCMD),
        .wbyte(wbyte), .be_done(be_done), .be_err(be_err), .be_err_code(be_err_code),
        .bsy(bsy_q), .err_flag(err_flag), .err_code(err_code), .pend(pend_q),
        .cmd_start(cmd_start), .cmd_code(cmd_code)
    );

    assign selected = (devhead[DEV_BIT] == dev_id);
    assign nien     = devctl[NIEN_BIT];
    assign par_cyl  = {cyl_hi, cyl_lo};
    assign par_head = devhead[HEAD_W-1:0];
    assign stat     = status_byte(bsy_q, be_drq, err_flag);
    assign intrq    = pend_q && !nien && selected;

    assign data_rd_en = bus_rd && selected && acc == ACC_DATA;
    assign data_wr_en = bus_wr && selected && acc == ACC_DATA;

    // Read mux: only readable slots drive, and only while selected.
    always_comb begin
        bus_rdata    = '0;
        bus_rdata_oe = 1'b0;
        if (bus_rd && selected) begin
            case (acc)
                ACC_DATA:    begin bus_rdata = be_rdata;                  bus_rdata_oe = 1'b1; end
                ACC_ERRFEAT: begin bus_rdata = {{PAD_W{1'b0}}, err_code}; bus_rdata_oe = 1'b1; end
                ACC_STATCMD,
                ACC_CTL:     begin bus_rdata = {{PAD_W{1'b0}}, stat};     bus_rdata_oe = 1'b1; end
                default:     ;
            endcase
        end
    end
endmodule

// File: rtl/ata_regfile_chk.sv
// Protocol checker for the register file, attached by bind.
module ata_regfile_chk (
    input logic clk,
    input logic rst_n,
    input logic wr_stb,
    input logic rd_stb,
    input logic cmd_start,
    input logic bsy,
    input logic pend,
    input logic nien,
    input logic selected,
    input logic intrq,
    input logic rdata_oe
);
    // R6
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) cmd_start |=> !cmd_start);
    // R6
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) cmd_start |-> bsy);
    // R6
    start_cause_chk: assert property (@(posedge clk) disable iff (!rst_n) cmd_start |-> $past(wr_stb));
    // R9
    nien_mask_chk: assert property (@(posedge clk) disable iff (!rst_n) nien |-> !intrq);
    // R5
    desel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n) !selected |-> (!rdata_oe && !intrq));
    // R4
    oe_read_chk: assert property (@(posedge clk) disable iff (!rst_n) rdata_oe |-> rd_stb);
    // R8
    irq_pend_chk: assert property (@(posedge clk) disable iff (!rst_n) intrq |-> pend);
endmodule

bind ata_regfile ata_regfile_chk u_chk (
    .clk(clk), .rst_n(rst_n), .wr_stb(bus_wr), .rd_stb(bus_rd),
    .cmd_start(cmd_start), .bsy(bsy_q), .pend(pend_q), .nien(nien),
    .selected(selected), .intrq(intrq), .rdata_oe(bus_rdata_oe)
);

// File: tb/tb_ata_regfile.sv
`timescale 1ns/1ps
module tb_ata_regfile;
    logic        clk = 0, rst_n = 0, dev_id = 0;
    logic        sc = 0, sl = 0, rd = 0, wr = 0;
    logic [2:0]  addr = 0;
    logic [15:0] wdata = 0, be_rdata = 0, rdata;
    logic        oe, intrq, cmd_start, be_done = 0, be_err = 0, be_drq = 0, drd, dwr;
    logic [7:0]  be_code = 0, cmd_code, pf, pc, ps;
    logic [15:0] pcyl;
    logic [3:0]  ph;
    int checks = 0, errors = 0;
    bit finished = 0;
    logic [15:0] r_val;
    logic        r_oe;

    always #2.5 clk = ~clk;

    ata_regfile dut (
        .clk(clk), .rst_n(rst_n), .dev_id(dev_id), .bus_sel_cmd(sc), .bus_sel_ctl(sl),
        .bus_addr(addr), .bus_rd(rd), .bus_wr(wr), .bus_wdata(wdata), .bus_rdata(rdata),
        .bus_rdata_oe(oe), .intrq(intrq), .cmd_start(cmd_start), .cmd_code(cmd_code),
        .par_feature(pf), .par_count(pc), .par_sector(ps), .par_cyl(pcyl), .par_head(ph),
        .be_done(be_done), .be_err(be_err), .be_err_code(be_code), .be_drq(be_drq),
        .be_rdata(be_rdata), .data_rd_en(drd), .data_wr_en(dwr)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    // ---------------- reference model ----------------
    logic [7:0] m_feat, m_cnt, m_sec, m_cl, m_ch, m_dh, m_ctl, m_code, m_ecode;
    logic       m_bsy, m_err, m_pend, m_start;

    // slot numbers: 0 none,1 data,2 err/feat,3..7 count..devhead,8 stat/cmd,9 ctl
    function automatic int slot(input logic s_c, input logic s_l, input logic [2:0] a);
        if (s_c && !s_l) return (a == 3'd7) ? 8 : int'(a) + 1;
        if (s_l && !s_c && a == 3'd6) return 9;
        return 0;
    endfunction

    always @(posedge clk) begin
        int k;
        bit sel, go;
        k = slot(sc, sl, addr);
        sel = (m_dh[4] == dev_id);
        if (!rst_n) begin
            {m_feat, m_cnt, m_sec, m_cl, m_ch, m_dh, m_ctl, m_code, m_ecode} = '0;
            {m_bsy, m_err, m_pend, m_start} = '0;
        end else begin
            go = wr && sel && k == 8 && !m_bsy;
            m_start = go;
            if (wr) begin
                if (k == 2) m_feat = wdata[7:0];
                if (k == 3) m_cnt  = wdata[7:0];
                if (k == 4) m_sec  = wdata[7:0];
                if (k == 5) m_cl   = wdata[7:0];
                if (k == 6) m_ch   = wdata[7:0];
                if (k == 7) m_dh   = wdata[7:0];
                if (k == 9) m_ctl  = wdata[7:0];
            end
            if (go) begin
                m_bsy = 1; m_code = wdata[7:0]; m_err = 0; m_ecode = 0; m_pend = 0;
            end else if (be_done && m_bsy) begin
                m_bsy = 0; m_err = be_err; m_ecode = be_err ? be_code : 8'h00; m_pend = 1;
            end else if (rd && sel && k == 8) begin
                m_pend = 0;
            end
        end
        #1;
        if (rst_n) begin
            logic [15:0] e_rd;
            logic e_oe;
            logic [7:0] st;
            k = slot(sc, sl, addr);
            sel = (m_dh[4] == dev_id);
            st = {m_bsy, ~m_bsy, 2'b00, be_drq, 2'b00, m_err};
            e_oe = 0; e_rd = 0;
            if (rd && sel) begin
                if (k == 1) begin e_oe = 1; e_rd = be_rdata; end
                if (k == 2) begin e_oe = 1; e_rd = {8'h00, m_ecode}; end
                if (k == 8 || k == 9) begin e_oe = 1; e_rd = {8'h00, st}; end
            end
            chk(intrq == (m_pend && !m_ctl[1] && sel), "R8 intrq", intrq, m_pend && !m_ctl[1] && sel);
            chk(cmd_start == m_start, "R6 cmd_start", cmd_start, m_start);
            chk(cmd_code == m_code, "R6 cmd_code", cmd_code, m_code);
            chk({pf, pc, ps, pcyl, ph} == {m_feat, m_cnt, m_sec, m_ch, m_cl, m_dh[3:0]},
                "R1 params", {pf, pc, ps, pcyl, ph}, {m_feat, m_cnt, m_sec, m_ch, m_cl, m_dh[3:0]});
            chk(oe == e_oe, "R4 rdata_oe", oe, e_oe);
            chk(rdata == e_rd, "R3 rdata", rdata, e_rd);
            chk(drd == (rd && sel && k == 1), "R10 data_rd_en", drd, rd && sel && k == 1);
            chk(dwr == (wr && sel && k == 1), "R10 data_wr_en", dwr, wr && sel && k == 1);
        end
    end

    // ---------------- stimulus tasks ----------------
    task automatic op(input logic c, input logic l, input logic [2:0] a, input logic r,
                      input logic w, input logic [15:0] d);
        @(negedge clk);
        sc = c; sl = l; addr = a; rd = r; wr = w; wdata = d;
        #1; r_val = rdata; r_oe = oe;
        @(negedge clk);
        sc = 0; sl = 0; rd = 0; wr = 0;
    endtask
    task automatic wreg(input logic [2:0] a, input logic [7:0] d); op(1, 0, a, 0, 1, {8'h00, d}); endtask
    task automatic rreg(input logic [2:0] a); op(1, 0, a, 1, 0, 16'h0); endtask
    task automatic finish_cmd(input logic e, input logic [7:0] code);
        @(negedge clk); be_done = 1; be_err = e; be_code = code;
        @(negedge clk); be_done = 0; be_err = 0;
    endtask

    initial begin
        #(5.0 * 200000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(intrq == 0 && cmd_start == 0 && pf == 0 && pcyl == 0 && ph == 0, "R11 reset", {intrq, pf}, 0);
        rst_n = 1;
        rreg(3'd7);
        chk(r_val == 16'h0040, "R11 status after reset", r_val, 16'h0040);

        // R1 parameter writes
        wreg(1, 8'h11); wreg(2, 8'h22); wreg(3, 8'h33); wreg(4, 8'h44); wreg(5, 8'h55); wreg(6, 8'hA3);
        chk({pf, pc, ps, pcyl, ph} == {8'h11, 8'h22, 8'h33, 16'h5544, 4'h3}, "R1 param outputs",
            {pf, pc, ps, pcyl, ph}, {8'h11, 8'h22, 8'h33, 16'h5544, 4'h3});
        // R4 write-only read
        rreg(2);
        chk(r_oe == 0 && r_val == 0, "R4 write-only read not driven", {r_oe, r_val}, 0);

        // R6 launch
        @(negedge clk); sc = 1; addr = 7; wr = 1; wdata = 16'h00C8;
        @(negedge clk); sc = 0; wr = 0;
        chk(cmd_start == 1 && cmd_code == 8'hC8, "R6 start pulse", {cmd_start, cmd_code}, 9'h1C8);
        @(negedge clk);
        chk(cmd_start == 0, "R6 pulse one cycle", cmd_start, 0);
        wreg(7, 8'h20);
        chk(cmd_start == 0 && cmd_code == 8'hC8, "R6 write while busy ignored", cmd_code, 8'hC8);
        // R2 alternate status
        op(0, 1, 3'd6, 1, 0, 0);
        chk(r_oe && r_val == 16'h0080, "R2 altstatus busy", r_val, 16'h0080);
        // R8 interrupt
        finish_cmd(0, 8'h00);
        chk(intrq == 1, "R8 intrq on done", intrq, 1);
        op(0, 1, 3'd6, 1, 0, 0);
        chk(intrq == 1, "R8 altstatus read keeps intrq", intrq, 1);
        rreg(7);
        chk(r_val == 16'h0040 && intrq == 0, "R8 status read clears", {r_val, intrq}, {16'h0040, 1'b0});

        // R7 / R3 error path
        wreg(7, 8'h30);
        finish_cmd(1, 8'h04);
        be_drq = 1;
        rreg(1);
        chk(r_oe && r_val == 16'h0004, "R3 error register read", r_val, 16'h0004);
        chk(pf == 8'h11, "R3 features unchanged by error read", pf, 8'h11);
        op(0, 1, 3'd6, 1, 0, 0);
        chk(r_val == 16'h0049, "R7 status err+drq", r_val, 16'h0049);
        be_drq = 0;
        rreg(7);

        // R9 mask
        op(0, 1, 3'd6, 0, 1, 16'h0002);
        wreg(7, 8'h40);
        finish_cmd(0, 0);
        chk(intrq == 0, "R9 masked", intrq, 0);
        op(0, 1, 3'd6, 0, 1, 16'h0000);
        chk(intrq == 1, "R9 pending shows after unmask", intrq, 1);

        // R2 other control offset ignored
        op(0, 1, 3'd5, 0, 1, 16'h0002);
        chk(intrq == 1, "R2 stray control write ignored", intrq, 1);
        op(1, 1, 3'd6, 0, 1, 16'h0002);
        chk(intrq == 1, "R2 dual select ignored", intrq, 1);

        // R10 data port
        be_rdata = 16'hBEEF;
        @(negedge clk); sc = 1; addr = 0; rd = 1; #1;
        chk(drd == 1 && rdata == 16'hBEEF && oe, "R10 data read", rdata, 16'hBEEF);
        @(negedge clk); rd = 0; wr = 1; wdata = 16'h1234; #1;
        chk(dwr == 1, "R10 data write strobe", dwr, 1);
        @(negedge clk); sc = 0; wr = 0;

        // R5 deselect
        wreg(6, 8'hB0);
        chk(intrq == 0 && ph == 4'h0, "R5 deselected hides intrq", intrq, 0);
        wreg(7, 8'h50);
        chk(cmd_start == 0, "R5 command ignored when deselected", cmd_start, 0);
        rreg(7);
        chk(r_oe == 0, "R5 no drive when deselected", r_oe, 0);
        wreg(1, 8'h77);
        chk(pf == 8'h77, "R5 params still accepted", pf, 8'h77);
        dev_id = 1;
        @(negedge clk);
        chk(intrq == 1, "R5 matching identity selects", intrq, 1);
        dev_id = 0;

        // random run against the model
        for (int i = 0; i < 4000; i++) begin
            int p;
            @(negedge clk);
            p = $urandom_range(0, 9);
            sc = $urandom_range(0, 3) != 0; sl = $urandom_range(0, 3) == 0;
            addr = 3'($urandom); wdata = 16'($urandom); be_rdata = 16'($urandom);
            rd = (p < 4); wr = (p >= 4 && p < 8);
            be_drq = 1'($urandom);
            be_done = ($urandom_range(0, 5) == 0); be_err = 1'($urandom); be_code = 8'($urandom);
            if (i % 500 == 250) begin rst_n = 0; end else rst_n = 1;
        end
        @(negedge clk); sc = 0; sl = 0; rd = 0; wr = 0; be_done = 0; rst_n = 1;
        repeat (3) @(negedge clk);
        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule